// File: doc/BRIEF.md
# Timer Channel with Pin Mode and Input Capture

This block is one channel of a timer array. Software picks its behaviour with a 7-bit mode field: it can act as a plain input pin that raises an event flag on chosen edges, as a plain output pin, or as an input-capture unit. In capture mode, each chosen edge on the pin copies the current value of a 24-bit time base into a capture register and raises the flag. The capture register is overwritten by every later qualifying edge, whether or not software has read it.

The pin input arrives already filtered and synchronised to the channel clock. A delayed copy of the pin, updated every cycle, forms the edge detector. To change between non-pin modes, software must first pass through one of the two pin modes. A capture unit entered any other way stays disarmed. The flag stays set until software writes a one to clear it.

Top module: `tmr_cap_chan`

## Requirements
- R1: After reset `cap_o` is 0, `flag_o` is 0 and `pin_o` is 0.
- R2: `pin_lvl_o` always equals the live level of `pin_i`, in every mode.
- R3: In mode 7'b0000000 (pin input), an edge sets `flag_o` after the clock edge at which `pin_i` differs from its delayed copy. When `edge_both_i`=1, both edges count and `edge_pol_i` is ignored. When `edge_both_i`=0, `edge_pol_i`=1 selects rising edges and 0 selects falling edges.
- R4: In mode 7'b0000001 (pin output), `pin_o` takes the value of `edge_pol_i` at every clock edge. In every other mode `pin_o` holds its value.
- R5: In mode 7'b0000010 (capture), a qualifying edge (selected as in R3) loads `tbase_i` into `cap_o` and sets `flag_o` at the same clock edge.
- R6: Every later qualifying edge in capture mode overwrites `cap_o` again, with no read and no flag clear needed in between.
- R7: `flag_o` holds until `flag_clr_i`=1 at a clock edge clears it. If a new event occurs at the same edge, the flag stays set.
- R8: No event is taken at a clock edge where `mode_i` differs from its value at the previous edge. Capture is armed only when capture mode is entered directly from mode 0 or mode 1. If it is entered from any other mode, no captures and no flags occur until the channel passes through a pin mode.
- R9: The delayed copy of the pin follows `pin_i` in every mode, so entering a mode while the pin is steady at either level produces no event.
- R10: In any mode other than 0, 1 or 2, `flag_o` is never set and `cap_o` never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 7 | Mode field (0 pin input, 1 pin output, 2 capture) |
| edge_both_i | input | 1 | 1: both edges qualify |
| edge_pol_i | input | 1 | Edge polarity (1 rising); output level in pin-output mode |
| pin_i | input | 1 | Filtered, synchronised pin level |
| tbase_i | input | TB_W | Selected time base |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the flag |
| cap_o | output | TB_W | Capture register readback |
| pin_lvl_o | output | 1 | Live pin level |
| flag_o | output | 1 | Sticky event flag |
| pin_o | output | 1 | Output flip-flop driving the pin |

## Verification
The assertions assume that `mode_i`, the edge controls and `pin_i` are synchronous to `clk` and steady around each rising edge. They also assume the pin has already been filtered, so a single-cycle pulse counts as two real edges. The bench changes every input one time unit after a rising edge and samples one time unit after the next edge. It changes modes only through the pin modes, except in the one case that checks the disarmed path. The time base is set explicitly before each edge, so the expected capture value is known without modelling a counter.

// File: rtl/tmr_cap_chan.sv
module tmr_cap_chan #(
  parameter int TB_W = 24,
  parameter int MODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              edge_both_i,
  input  logic              edge_pol_i,
  input  logic              pin_i,
  input  logic [TB_W-1:0]   tbase_i,
  input  logic              flag_clr_i,
  output logic [TB_W-1:0]   cap_o,
  output logic              pin_lvl_o,
  output logic              flag_o,
  output logic              pin_o
);
  localparam logic [MODE_W-1:0] M_PIN_IN  = MODE_W'(0);
  localparam logic [MODE_W-1:0] M_PIN_OUT = MODE_W'(1);
  localparam logic [MODE_W-1:0] M_CAPT    = MODE_W'(2);

  logic [MODE_W-1:0] mode_q;
  logic              pin_q;
  logic              armed_q;
  logic              hit, steady, pin_mode_q, ev_in, ev_cap, ev;

  assign pin_lvl_o  = pin_i;
  assign steady     = (mode_i == mode_q);
  assign pin_mode_q = (mode_q == M_PIN_IN) || (mode_q == M_PIN_OUT);

  always_comb begin
    if (edge_both_i)     hit = pin_i ^ pin_q;
    else if (edge_pol_i) hit = pin_i & ~pin_q;
    else                 hit = ~pin_i & pin_q;
  end

  assign ev_in  = hit && steady && (mode_i == M_PIN_IN);
  assign ev_cap = hit && steady && (mode_i == M_CAPT) && armed_q;
  assign ev     = ev_in || ev_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_PIN_IN;
      pin_q   <= 1'b0;
      armed_q <= 1'b0;
      cap_o   <= '0;
      flag_o  <= 1'b0;
      pin_o   <= 1'b0;
    end else begin
      mode_q <= mode_i;
      pin_q  <= pin_i;
      if (mode_i != M_CAPT)
        armed_q <= 1'b0;
      else if (!steady && pin_mode_q)
        armed_q <= 1'b1;
      if (ev_cap)
        cap_o <= tbase_i;
      flag_o <= ev || (flag_o && !flag_clr_i);
      if (mode_i == M_PIN_OUT)
        pin_o <= edge_pol_i;
    end
  end
endmodule

module tmr_cap_chan_chk #(
  parameter int TB_W = 24,
  parameter int MODE_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] mode_i,
  input logic              edge_pol_i,
  input logic              flag_clr_i,
  input logic [TB_W-1:0]   cap_o,
  input logic              flag_o,
  input logic              pin_o
);
  AST_FLAG_ONLY_IN_EVENT_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> ($past(mode_i) == MODE_W'(0) || $past(mode_i) == MODE_W'(2))); // R10
  AST_CAP_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_o) |-> ($past(mode_i) == MODE_W'(2) && flag_o)); // R5
  AST_PIN_OUT_FOLLOWS_POL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_W'(1)) |=> (pin_o == $past(edge_pol_i))); // R4
  AST_PIN_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != MODE_W'(1)) |=> $stable(pin_o)); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flag_clr_i) |=> flag_o); // R7
endmodule

bind tmr_cap_chan tmr_cap_chan_chk #(.TB_W(TB_W), .MODE_W(MODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .edge_pol_i(edge_pol_i),
  .flag_clr_i(flag_clr_i), .cap_o(cap_o), .flag_o(flag_o), .pin_o(pin_o));

// File: tb/tmr_cap_chan_tb.sv
`timescale 1ns/1ps
module tmr_cap_chan_tb_top;
  localparam int TB_W = 24;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [6:0] mode_i = '0;
  logic edge_both_i = 1'b0, edge_pol_i = 1'b0, pin_i = 1'b0, flag_clr_i = 1'b0;
  logic [TB_W-1:0] tbase_i = '0;
  logic [TB_W-1:0] cap_o;
  logic pin_lvl_o, flag_o, pin_o;
  int checks = 0, errors = 0;
  logic [TB_W-1:0] exp_cap = '0;

  always #2.5 clk = ~clk;

  tmr_cap_chan #(.TB_W(TB_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .edge_both_i(edge_both_i),
    .edge_pol_i(edge_pol_i), .pin_i(pin_i), .tbase_i(tbase_i), .flag_clr_i(flag_clr_i),
    .cap_o(cap_o), .pin_lvl_o(pin_lvl_o), .flag_o(flag_o), .pin_o(pin_o));

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [TB_W-1:0] act, logic [TB_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr_flag();
    flag_clr_i = 1'b1; tick(); flag_clr_i = 1'b0;
  endtask

  function automatic logic qual(logic both, logic pol, logic rise);
    return both || (pol == rise);
  endfunction

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick();
    chk("R1 cap", cap_o, 0);
    chk("R1 flag", {23'd0, flag_o}, 0);
    chk("R1 pin_o", {23'd0, pin_o}, 0);

    for (int v = 0; v < 2; v++) begin
      pin_i = v[0]; #1;
      chk("R2 level", {23'd0, pin_lvl_o}, {23'd0, v[0]});
    end
    pin_i = 1'b0; tick(2);

    // R3 sweep: pin input mode
    for (int k = 0; k < 8; k++) begin
      logic both, pol, rise;
      both = k[2]; pol = k[1]; rise = k[0];
      mode_i = 7'd0; edge_both_i = both; edge_pol_i = pol;
      pin_i = ~rise; tick(2); clr_flag();
      pin_i = rise; tick();
      chk("R3 gpio-in flag", {23'd0, flag_o}, {23'd0, qual(both, pol, rise)});
      clr_flag();
    end

    // R5 sweep: capture mode entered from pin input
    for (int k = 0; k < 8; k++) begin
      logic both, pol, rise;
      both = k[2]; pol = k[1]; rise = k[0];
      mode_i = 7'd0; edge_both_i = both; edge_pol_i = pol;
      pin_i = ~rise; tick(); clr_flag();
      mode_i = 7'd2; tick(2);
      tbase_i = 24'h001000 + 24'(k * 24'h250);
      pin_i = rise; tick();
      if (qual(both, pol, rise)) exp_cap = tbase_i;
      chk("R5 capture value", cap_o, exp_cap);
      chk("R5 capture flag", {23'd0, flag_o}, {23'd0, qual(both, pol, rise)});
      clr_flag();
    end

    // R6: repeated captures, no read, no clear
    edge_both_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      tbase_i = 24'h0016A0 + 24'(k * 24'h111);
      pin_i = ~pin_i; tick();
      exp_cap = tbase_i;
      chk("R6 overwrite", cap_o, exp_cap);
      chk("R6 flag", {23'd0, flag_o}, 1);
    end

    // R7: clear alone, then clear with event
    clr_flag();
    chk("R7 cleared", {23'd0, flag_o}, 0);
    tbase_i = 24'h0A0A0A; pin_i = ~pin_i; flag_clr_i = 1'b1; tick(); flag_clr_i = 1'b0;
    exp_cap = tbase_i;
    chk("R7 event wins", {23'd0, flag_o}, 1);
    tick(3);
    chk("R7 sticky", {23'd0, flag_o}, 1);
    clr_flag();

    // R8: mode-change cycle edge ignored; entry from other mode disarms
    mode_i = 7'd0; tick();
    mode_i = 7'd2; pin_i = ~pin_i; tbase_i = 24'h123456; tick();
    chk("R8 change-cycle no flag", {23'd0, flag_o}, 0);
    chk("R8 change-cycle no cap", cap_o, exp_cap);
    mode_i = 7'd3; tick(2);
    mode_i = 7'd2; tick(2);
    pin_i = ~pin_i; tick();
    chk("R8 disarmed no cap", cap_o, exp_cap);
    chk("R8 disarmed no flag", {23'd0, flag_o}, 0);
    mode_i = 7'd1; tick(); mode_i = 7'd2; tick(2);
    tbase_i = 24'h654321; pin_i = ~pin_i; tick();
    exp_cap = tbase_i;
    chk("R8 rearmed cap", cap_o, exp_cap);
    clr_flag();

    // R9: steady pin across mode entry, both levels
    for (int lv = 0; lv < 2; lv++) begin
      mode_i = 7'd0; pin_i = lv[0]; tick(3); clr_flag();
      mode_i = 7'd2; tick(3);
      chk("R9 no false edge flag", {23'd0, flag_o}, 0);
      chk("R9 no false edge cap", cap_o, exp_cap);
    end

    // R4: pin output
    mode_i = 7'd0; tick(); mode_i = 7'd1;
    for (int v = 0; v < 4; v++) begin
      edge_pol_i = v[0]; tick();
      chk("R4 out follows", {23'd0, pin_o}, {23'd0, v[0]});
    end
    mode_i = 7'd0; edge_pol_i = 1'b0; tick(); mode_i = 7'd1; edge_pol_i = 1'b1; tick();
    mode_i = 7'd0; edge_pol_i = 1'b0; tick(3);
    chk("R4 out holds", {23'd0, pin_o}, 1);
    clr_flag();

    // R10: unsupported modes
    for (int m = 3; m < 128; m += 31) begin
      mode_i = 7'd0; tick(); mode_i = 7'(m); edge_both_i = 1'b1; tick(2);
      pin_i = ~pin_i; tbase_i = 24'hFFFFFF; tick(); pin_i = ~pin_i; tick();
      chk("R10 no flag", {23'd0, flag_o}, 0);
      chk("R10 no cap", cap_o, exp_cap);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule